// File: doc/BRIEF.md
# Configurable SPI Shift Engine

This block moves one serial word of 2 to 16 bits in and out at the same time over a pair of data lines. Each word carries its own format. The caller picks that format by giving a small index with the word. The index selects one of several format registers. Each register holds a character length, a clock polarity, a clock phase, a bit-order select and an 11-bit rate divider. Because the format is chosen again for every word, a single port can serve peripherals that need different framings, one word after another.

The same shift path works in two clock roles. As clock master, the engine builds the serial clock from the system clock. Each half period of that clock lasts divider + 1 system cycles. As clock slave, the engine follows an external serial clock and data line. Both are passed through two synchronizing flops and edge-detected in the system clock domain. The host starts a word with a one-cycle load strobe. When the word ends, the received bits are copied into a holding register and a one-cycle done pulse is raised. A sticky overrun flag records that an unread word was overwritten.

Top module: `spi_word_engine`

## Requirements
- R1: The length field occupies bits [4:0] of a format word. A stored value below 2 becomes 2, and a value above 16 becomes 16. A word produces exactly 2 × length serial clock transitions.
- R2: In master mode, the first serial clock transition comes divider + 1 system cycles after the cycle in which the load was accepted. Every later transition follows the previous one after divider + 1 cycles. The divider occupies bits [18:8] of a format word.
- R3: The polarity bit (bit 5 of a format word) sets the idle level. Whenever no word is in flight, the serial clock output rests at the polarity of the most recently loaded format.
- R4: The phase bit is bit 6 of a format word. With phase 0, the first data bit is on the output from the cycle after the load, and each received bit is taken on a leading edge. With phase 1, data bits change on leading edges and are taken on trailing edges.
- R5: The order bit is bit 7 of a format word. With the order bit clear, bits leave most significant first, counted within the programmed length. With the order bit set, bit 0 leaves first.
- R6: When a word ends, the holding register receives the received bits right-justified, with upper bits zero. rx_valid is set, and done is high for exactly one cycle.
- R7: If a word ends while rx_valid is still set and rx_read is low, overrun is set and the holding register takes the new word. rx_read clears both rx_valid and overrun.
- R8: With master_en low, the engine shifts on the external serial clock after synchronization, using the selected format, and ends the word after 2 × length external transitions.
- R9: The format applied to a word is the register addressed by tx_fmt in the load cycle. The registers are written through fmt_wr_en, fmt_wr_idx and fmt_wr_data.
- R10: A load strobe while a word is in flight is ignored: the word being shifted and its timing are unchanged.
- R11: After reset, busy, done, rx_valid, overrun, sclk_o and sdo are all 0 and rx_data is zero. Each format register resets to length 8, polarity 0, phase 0, most significant bit first and divider 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1: drive the serial clock; 0: follow sclk_i |
| fmt_wr_en | input | 1 | Write strobe for a format register |
| fmt_wr_idx | input | IDXW | Format register to write |
| fmt_wr_data | input | 19 | Format word {divider, order, phase, polarity, length} |
| tx_load | input | 1 | Start a word (ignored while busy) |
| tx_word | input | 16 | Word to send, right-justified |
| tx_fmt | input | IDXW | Format index used by the loaded word |
| rx_read | input | 1 | Acknowledge the holding register |
| sclk_i | input | 1 | External serial clock (slave mode) |
| sdi | input | 1 | Serial data in |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | A word is in flight |
| done | output | 1 | One-cycle pulse when a word ends |
| rx_data | output | 16 | Last received word, right-justified |
| rx_valid | output | 1 | Holding register has an unread word |
| overrun | output | 1 | An unread word was overwritten |

## Verification
A wrong edge counter or a wrong length clamp shows up as a word with the wrong number of clock transitions. It also shows up as a done pulse that arrives too early or too late, so it is visible within a single word. A wrong divider count shows up as a wrong transition spacing, starting with the first transition after the load. A wrong bit order, phase or justification in the shift register corrupts the sdo bit sequence and the received rx_data word for that same word. A wrong holding-register state shows up as an overrun flag or rx_valid level that does not match the read history, at the done pulse of the next word.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam int SW   = 16;  // widest character, shift register width
  localparam int DIVW = 11;  // rate divider width
  localparam int LENW = 5;   // character length field width

  typedef struct packed {
    logic [DIVW-1:0] div;
    logic            lsbf;
    logic            cpha;
    logic            cpol;
    logic [LENW-1:0] len;
  } fmt_t;

  localparam int FMTW = $bits(fmt_t);

  function automatic logic [LENW-1:0] clamp_len(input logic [LENW-1:0] l);
    if (l < LENW'(2))       return LENW'(2);
    else if (l > LENW'(SW)) return LENW'(SW);
    else                    return l;
  endfunction

  function automatic logic [LENW:0] edge_total(input logic [LENW-1:0] l);
    return {l, 1'b0};
  endfunction

  function automatic logic [SW-1:0] len_mask(input logic [LENW-1:0] l);
    logic [SW:0] one_h;
    logic [SW:0] m;
    one_h = (SW+1)'(1);
    m = (one_h << l) - (SW+1)'(1);
    return m[SW-1:0];
  endfunction

  // place the first bit to leave at the head end of the shift register
  function automatic logic [SW-1:0] justify(input logic [SW-1:0] w,
                                            input logic [LENW-1:0] l,
                                            input logic lsbf);
    if (lsbf) return w;
    else      return w << (SW - int'(l));
  endfunction

  function automatic logic [SW-1:0] extract(input logic [SW-1:0] sh,
                                            input logic [LENW-1:0] l,
                                            input logic lsbf);
    if (lsbf) return sh >> (SW - int'(l));
    else      return sh & len_mask(l);
  endfunction

  function automatic logic head(input logic [SW-1:0] sh, input logic lsbf);
    return lsbf ? sh[0] : sh[SW-1];
  endfunction

  function automatic logic [SW-1:0] shift_in(input logic [SW-1:0] sh,
                                             input logic b,
                                             input logic lsbf);
    if (lsbf) return {b, sh[SW-1:1]};
    else      return {sh[SW-2:0], b};
  endfunction

endpackage

// File: rtl/spi_fmt_bank.sv
module spi_fmt_bank
  import spi_eng_pkg::*;
#(
  parameter int NFMT = 4,
  parameter int IDXW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  fmt_t            wr_data,
  input  logic [IDXW-1:0] rd_idx,
  output fmt_t            rd_fmt
);

  localparam logic [LENW-1:0] RST_LEN = LENW'(8);

  fmt_t regs [NFMT];

  for (genvar g = 0; g < NFMT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[g]     <= '0;
        regs[g].len <= RST_LEN;
      end else if (wr_en && (wr_idx == IDXW'(g))) begin
        regs[g]     <= wr_data;
        regs[g].len <= clamp_len(wr_data.len);
      end
    end
  end

  assign rd_fmt = (int'(rd_idx) < NFMT) ? regs[rd_idx] : regs[0];

  // R1
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fmt.len >= LENW'(2)) && (rd_fmt.len <= LENW'(SW)));

endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
  import spi_eng_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  input  logic            cpol,
  output logic            tick_o,
  output logic            lead_o,
  output logic            sclk_o
);

  logic [DIVW-1:0] cnt;
  logic            act;

  assign tick_o = run && (cnt == div);
  assign lead_o = tick_o && !act;
  assign sclk_o = cpol ^ act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      act <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      act <= 1'b0;
    end else if (tick_o) begin
      cnt <= '0;
      act <= ~act;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2
  edge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && (div != '0)) |=> !tick_o);

  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && $past(!run)) |-> (sclk_o == cpol));

endmodule

// File: rtl/spi_slave_sync.sv
module spi_slave_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic sdi_i,
  input  logic cpol,
  output logic lead_o,
  output logic trail_o,
  output logic sdi_o
);

  logic [2:0] ck_q;
  logic [1:0] d_q;
  logic       act_now, act_was;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q <= '0;
      d_q  <= '0;
    end else begin
      ck_q <= {ck_q[1:0], sclk_i};
      d_q  <= {d_q[0], sdi_i};
    end
  end

  assign act_now = ck_q[1] ^ cpol;
  assign act_was = ck_q[2] ^ cpol;
  assign lead_o  = act_now && !act_was;
  assign trail_o = !act_now && act_was;
  assign sdi_o   = d_q[1];

  // R8
  sync_lead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lead_o |=> !lead_o);

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_eng_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [SW-1:0] tx_word_i,
  input  fmt_t          fmt_i,
  input  logic          tick_i,
  input  logic          lead_i,
  input  logic          sdi_i,
  output logic          busy_o,
  output logic          sdo_o,
  output fmt_t          cur_o,
  output logic          fin_o,
  output logic [SW-1:0] fin_word_o
);

  fmt_t          cur;
  logic [SW-1:0] shreg, shreg_nxt, start_sh;
  logic [LENW:0] ecnt;
  logic          out_bit, busy;
  logic          accept, sample_ev, launch_ev, last_ev;

  assign accept    = load_i && !busy;
  assign sample_ev = busy && tick_i && (lead_i ^ cur.cpha);
  assign launch_ev = busy && tick_i && !(lead_i ^ cur.cpha);
  assign last_ev   = busy && tick_i && (ecnt == edge_total(cur.len) - 1'b1);
  assign shreg_nxt = sample_ev ? shift_in(shreg, sdi_i, cur.lsbf) : shreg;
  assign start_sh  = justify(tx_word_i, fmt_i.len, fmt_i.lsbf);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur     <= '0;
      shreg   <= '0;
      ecnt    <= '0;
      out_bit <= 1'b0;
      busy    <= 1'b0;
    end else if (accept) begin
      cur   <= fmt_i;
      shreg <= start_sh;
      ecnt  <= '0;
      busy  <= 1'b1;
      if (!fmt_i.cpha) out_bit <= head(start_sh, fmt_i.lsbf);
    end else if (busy && tick_i) begin
      shreg <= shreg_nxt;
      ecnt  <= ecnt + 1'b1;
      if (launch_ev) out_bit <= head(shreg, cur.lsbf);
      if (last_ev)   busy    <= 1'b0;
    end
  end

  assign busy_o     = busy;
  assign sdo_o      = out_bit;
  assign cur_o      = cur;
  assign fin_o      = last_ev;
  assign fin_word_o = extract(shreg_nxt, cur.len, cur.lsbf);

  // R1
  ecnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ecnt < edge_total(cur.len)));

  // R10
  load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load_i && !tick_i) |=> ($stable(shreg) && $stable(cur)));

  // R4
  sdo_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(out_bit) |-> $past(accept || launch_ev));

endmodule

// File: rtl/spi_rx_hold.sv
module spi_rx_hold
  import spi_eng_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fin_i,
  input  logic [SW-1:0] word_i,
  input  logic          rd_i,
  output logic [SW-1:0] rx_data_o,
  output logic          rx_valid_o,
  output logic          overrun_o,
  output logic          done_o
);

  logic [SW-1:0] hold;
  logic          valid, ovr, done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold  <= '0;
      valid <= 1'b0;
      ovr   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= fin_i;
      if (fin_i) begin
        hold  <= word_i;
        valid <= 1'b1;
      end else if (rd_i) begin
        valid <= 1'b0;
      end
      if (rd_i)                        ovr <= 1'b0;
      else if (fin_i && valid)         ovr <= 1'b1;
    end
  end

  assign rx_data_o  = hold;
  assign rx_valid_o = valid;
  assign overrun_o  = ovr;
  assign done_o     = done;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(fin_i && valid && !rd_i));

  // R6
  valid_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> valid);

endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine
  import spi_eng_pkg::*;
#(
  parameter int NFMT = 4,
  parameter int IDXW = (NFMT > 1) ? $clog2(NFMT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            master_en,
  input  logic            fmt_wr_en,
  input  logic [IDXW-1:0] fmt_wr_idx,
  input  logic [FMTW-1:0] fmt_wr_data,
  input  logic            tx_load,
  input  logic [SW-1:0]   tx_word,
  input  logic [IDXW-1:0] tx_fmt,
  input  logic            rx_read,
  input  logic            sclk_i,
  input  logic            sdi,
  output logic            sclk_o,
  output logic            sdo,
  output logic            busy,
  output logic            done,
  output logic [SW-1:0]   rx_data,
  output logic            rx_valid,
  output logic            overrun
);

  fmt_t          sel_fmt, cur_fmt, wr_fmt;
  logic          core_busy, run;
  logic          m_tick, m_lead;
  logic          s_lead, s_trail, s_sdi;
  logic          tick, lead, sdi_mux;
  logic          fin;
  logic [SW-1:0] fin_word;

  assign wr_fmt = fmt_t'(fmt_wr_data);

  spi_fmt_bank #(.NFMT(NFMT), .IDXW(IDXW)) u_fmt (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (fmt_wr_en),
    .wr_idx  (fmt_wr_idx),
    .wr_data (wr_fmt),
    .rd_idx  (tx_fmt),
    .rd_fmt  (sel_fmt)
  );

  assign run = core_busy && master_en;

  spi_baud_gen u_baud (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .div    (cur_fmt.div),
    .cpol   (cur_fmt.cpol),
    .tick_o (m_tick),
    .lead_o (m_lead),
    .sclk_o (sclk_o)
  );

  spi_slave_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_i  (sclk_i),
    .sdi_i   (sdi),
    .cpol    (cur_fmt.cpol),
    .lead_o  (s_lead),
    .trail_o (s_trail),
    .sdi_o   (s_sdi)
  );

  assign tick    = master_en ? m_tick : (s_lead || s_trail);
  assign lead    = master_en ? m_lead : s_lead;
  assign sdi_mux = master_en ? sdi    : s_sdi;

  spi_shift_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tx_load),
    .tx_word_i  (tx_word),
    .fmt_i      (sel_fmt),
    .tick_i     (tick),
    .lead_i     (lead),
    .sdi_i      (sdi_mux),
    .busy_o     (core_busy),
    .sdo_o      (sdo),
    .cur_o      (cur_fmt),
    .fin_o      (fin),
    .fin_word_o (fin_word)
  );

  spi_rx_hold u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .fin_i      (fin),
    .word_i     (fin_word),
    .rd_i       (rx_read),
    .rx_data_o  (rx_data),
    .rx_valid_o (rx_valid),
    .overrun_o  (overrun),
    .done_o     (done)
  );

  assign busy = core_busy;

  // R6
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

endmodule

// File: tb/sim_spi_word_engine.sv
module sim_spi_word_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, master_en = 1'b0;
  logic        fmt_wr_en = 1'b0;
  logic [1:0]  fmt_wr_idx = '0, tx_fmt = '0;
  logic [18:0] fmt_wr_data = '0;
  logic        tx_load = 1'b0, rx_read = 1'b0, sclk_i = 1'b0, sdi = 1'b0;
  logic [15:0] tx_word = '0;
  logic        sclk_o, sdo, busy, done, rx_valid, overrun;
  logic [15:0] rx_data;

  int n_chk = 0, n_bad = 0, done_cnt = 0;
  int f_len[4], f_div[4];
  bit f_cpol[4], f_cpha[4], f_lsb[4];

  spi_word_engine u0 (
    .clk(clk), .rst_n(rst_n), .master_en(master_en),
    .fmt_wr_en(fmt_wr_en), .fmt_wr_idx(fmt_wr_idx), .fmt_wr_data(fmt_wr_data),
    .tx_load(tx_load), .tx_word(tx_word), .tx_fmt(tx_fmt), .rx_read(rx_read),
    .sclk_i(sclk_i), .sdi(sdi), .sclk_o(sclk_o), .sdo(sdo), .busy(busy),
    .done(done), .rx_data(rx_data), .rx_valid(rx_valid), .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (done === 1'b1) done_cnt++;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int bit_at(logic [15:0] w, int k, int len, bit lsb);
    return lsb ? int'(w[k]) : int'(w[len-1-k]);
  endfunction

  function automatic int masked(logic [15:0] w, int len);
    int r = 0;
    for (int i = 0; i < len; i++) r += int'(w[i]) << i;
    return r;
  endfunction

  task automatic set_fmt(int idx, int len_raw, bit cpol, bit cpha, bit lsb, int div);
    @(negedge clk);
    fmt_wr_en = 1'b1; fmt_wr_idx = 2'(idx);
    fmt_wr_data = {11'(div), lsb, cpha, cpol, 5'(len_raw)};
    f_len[idx] = (len_raw < 2) ? 2 : (len_raw > 16) ? 16 : len_raw;
    f_div[idx] = div; f_cpol[idx] = cpol; f_cpha[idx] = cpha; f_lsb[idx] = lsb;
    @(negedge clk);
    fmt_wr_en = 1'b0;
  endtask

  task automatic pulse_read();
    @(negedge clk); rx_read = 1'b1;
    @(negedge clk); rx_read = 1'b0;
  endtask

  // master word: bench plays the peer, watches sclk_o, checks timing and bits
  task automatic run_master(int idx, logic [15:0] tx, logic [15:0] peer, bit poke, bit do_read);
    int len, div, edges, gap, sidx, pidx, bad_gap, bad_bits, cyc, dn0;
    bit cpol, cpha, lsb, prev, lead;
    len = f_len[idx]; div = f_div[idx]; cpol = f_cpol[idx]; cpha = f_cpha[idx]; lsb = f_lsb[idx];
    edges = 0; sidx = 0; pidx = 0; bad_gap = 0; bad_bits = 0; dn0 = done_cnt;
    @(negedge clk);
    tx_word = tx; tx_fmt = 2'(idx); tx_load = 1'b1;
    if (!cpha) begin sdi = 1'(bit_at(peer, 0, len, lsb)); pidx = 1; end
    prev = cpol;
    @(negedge clk);
    tx_load = 1'b0; cyc = 1; gap = 1;
    if (!cpha) chk("R4", "first bit before any edge", int'(sdo), bit_at(tx, 0, len, lsb));
    while (cyc < 5000) begin
      if (poke && cyc == 3) begin tx_word = ~tx; tx_load = 1'b1; end
      else tx_load = 1'b0;
      if (sclk_o !== prev) begin
        edges++;
        if (gap != ((edges == 1) ? div + 2 : div + 1)) bad_gap++;
        gap = 0;
        lead = (sclk_o != cpol);
        prev = sclk_o;
        if (lead ^ cpha) begin
          if (sidx < len && int'(sdo) != bit_at(tx, sidx, len, lsb)) bad_bits++;
          sidx++;
        end else begin
          if (pidx < len) sdi = 1'(bit_at(peer, pidx, len, lsb));
          pidx++;
        end
      end
      if (!busy) break;
      @(negedge clk); cyc++; gap++;
    end
    tx_load = 1'b0;
    @(negedge clk);
    chk("R1 R9", "clock transitions per word", edges, 2*len);
    chk("R2", "transition spacing errors", bad_gap, 0);
    chk("R5 R10", "sdo bit errors", bad_bits, 0);
    chk("R5", "bits sampled", sidx, len);
    chk("R3", "idle clock level", int'(sclk_o), int'(cpol));
    chk("R6", "done pulses", done_cnt - dn0, 1);
    chk("R6", "rx_data", int'(rx_data), masked(peer, len));
    chk("R6", "rx_valid", int'(rx_valid), 1);
    if (poke) chk("R10", "busy after word", int'(busy), 0);
    if (do_read) pulse_read();
  endtask

  // slave word: bench plays the clock master on sclk_i
  task automatic run_slave(int idx, logic [15:0] tx, logic [15:0] peer, int half);
    int len, sidx, pidx, bad_bits, dn0;
    bit cpol, cpha, lsb, lead;
    len = f_len[idx]; cpol = f_cpol[idx]; cpha = f_cpha[idx]; lsb = f_lsb[idx];
    sidx = 0; pidx = 0; bad_bits = 0; dn0 = done_cnt;
    @(negedge clk); sclk_i = cpol;
    repeat (4) @(negedge clk);
    tx_word = tx; tx_fmt = 2'(idx); tx_load = 1'b1;
    if (!cpha) begin sdi = 1'(bit_at(peer, 0, len, lsb)); pidx = 1; end
    @(negedge clk); tx_load = 1'b0;
    repeat (half) @(negedge clk);
    for (int e = 0; e < 2*len; e++) begin
      lead = (e % 2 == 0);
      if (lead ^ cpha) begin
        if (int'(sdo) != bit_at(tx, sidx, len, lsb)) bad_bits++;
        sidx++;
      end
      sclk_i = ~sclk_i;
      if (!(lead ^ cpha)) begin
        if (pidx < len) sdi = 1'(bit_at(peer, pidx, len, lsb));
        pidx++;
      end
      repeat (half) @(negedge clk);
    end
    chk("R8", "slave sdo bit errors", bad_bits, 0);
    chk("R8", "slave done pulses", done_cnt - dn0, 1);
    chk("R8", "slave rx_data", int'(rx_data), masked(peer, len));
    chk("R8", "slave busy after word", int'(busy), 0);
    pulse_read();
  endtask

  task automatic test_reset();
    chk("R11", "busy", int'(busy), 0);
    chk("R11", "done", int'(done), 0);
    chk("R11", "rx_valid", int'(rx_valid), 0);
    chk("R11", "overrun", int'(overrun), 0);
    chk("R11", "sclk_o", int'(sclk_o), 0);
    chk("R11", "sdo", int'(sdo), 0);
    chk("R11", "rx_data", int'(rx_data), 0);
  endtask

  task automatic test_reset_format();
    f_len[2] = 8; f_div[2] = 0; f_cpol[2] = 0; f_cpha[2] = 0; f_lsb[2] = 0;
    run_master(2, 16'h0096, 16'h0071, 1'b0, 1'b1);  // R11 default format
  endtask

  task automatic test_formats();
    set_fmt(0, 8, 1'b0, 1'b0, 1'b0, 1);
    set_fmt(1, 12, 1'b1, 1'b1, 1'b1, 3);
    set_fmt(2, 16, 1'b0, 1'b1, 1'b0, 0);
    set_fmt(3, 5, 1'b1, 1'b0, 1'b1, 2);
    run_master(0, 16'h00A5, 16'h003C, 1'b0, 1'b1);
    run_master(1, 16'h0B37, 16'h0C59, 1'b0, 1'b1);
    run_master(2, 16'hD00F, 16'h8E21, 1'b0, 1'b1);
    run_master(3, 16'h0013, 16'h000A, 1'b0, 1'b1);
    run_master(1, 16'h05E2, 16'h0A1D, 1'b0, 1'b1);   // R9 index switch back
  endtask

  task automatic test_busy_load();
    run_master(0, 16'h00C3, 16'h005A, 1'b1, 1'b1);   // R10
  endtask

  task automatic test_clamp();
    set_fmt(3, 1, 1'b0, 1'b0, 1'b0, 0);              // R1 low clamp
    run_master(3, 16'h0002, 16'h0001, 1'b0, 1'b1);
    set_fmt(3, 20, 1'b0, 1'b1, 1'b1, 1);             // R1 high clamp
    run_master(3, 16'h8001, 16'h4002, 1'b0, 1'b1);
  endtask

  task automatic test_overrun();
    set_fmt(2, 4, 1'b0, 1'b0, 1'b0, 0);
    run_master(2, 16'h0005, 16'h0003, 1'b0, 1'b0);
    chk("R7", "no overrun after first word", int'(overrun), 0);
    run_master(2, 16'h0009, 16'h0006, 1'b0, 1'b0);
    chk("R7", "overrun set", int'(overrun), 1);
    chk("R7", "buffer overwritten", int'(rx_data), 6);
    pulse_read();
    chk("R7", "overrun cleared by read", int'(overrun), 0);
    chk("R7", "rx_valid cleared by read", int'(rx_valid), 0);
  endtask

  task automatic test_slave();
    @(negedge clk); master_en = 1'b0;
    set_fmt(0, 8, 1'b0, 1'b0, 1'b0, 0);
    run_slave(0, 16'h005A, 16'h0093, 6);
    set_fmt(1, 10, 1'b1, 1'b1, 1'b1, 0);
    run_slave(1, 16'h02C7, 16'h01B4, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    master_en = 1'b1;
    test_reset_format();
    test_formats();
    test_busy_load();
    test_clamp();
    test_overrun();
    test_slave();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule